// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Register-Empty Flags

This block turns bytes into asynchronous serial frames on a single output line. It keeps two storage stages: a one-word holding register that accepts writes, and a frame shifter that drives the line. Time is counted in ticks of a 16x bit-rate enable, and each bit lasts one full count of that enable. Each frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop bit.

Two flags tell the host what the transmitter can take. The holding-empty flag does not rise when a word moves into the shifter. It rises a fixed two ticks into the first data bit of that word's frame. The all-empty flag is high only when the shifter is idle and the holding register is empty. While it is high, a write goes straight into the shifter and its start bit appears on the line at once.

Two commands act only on an all-empty transmitter. One sends a frame-length run of marks (an idle preamble). The other sends a frame-length run of spaces (a break). A clear pulse and a stop-mode level both abandon any transfer and return both flags to their reset values.

Writes use a valid/ready handshake. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` equals the holding-empty flag, gated off during clear and stop mode. A producer holds `wr_valid` and `wr_data` steady until the word is taken. The flag-based interrupt request is a plain level output.

Top module: `txu_async_tx`

## Requirements
- R1: After reset, `dre` = 1, `tx_empty` = 1, `wr_ready` = 1 and `txd` = 1.
- R2: `wr_ready` is 1 exactly when `dre` is 1 and neither `clr` nor `stop_mode` is asserted. An accepted write drives `dre` to 0 on the following cycle.
- R3: A data frame is one 0 start bit, then `wr_data` bits 0 to 7, then an even parity bit, then a 1 stop bit. With the default parameters this is 11 bits. The parity bit is the XOR of the data bits. Every bit lasts 16 ticks of `tick16`.
- R4: `dre` stays 0 through the load of a word into the shifter and through its whole start bit. It rises on the 18th tick after the load: 16 ticks of start bit plus 2 ticks into data bit 0.
- R5: `tx_empty` is 1 only when no frame is being shifted and the holding register is empty. A write accepted while `tx_empty` = 1 drives `txd` to 0 (the start bit) and `tx_empty` to 0 on the next cycle.
- R6: If the holding register is full when a frame's stop bit ends, the held word's start bit begins on that same tick, with no idle time on the line.
- R7: When `tx_empty` = 1, a `cmd_idle` pulse sends 11 bit-times of 1 and a `cmd_break` pulse sends 11 bit-times of 0. Either command clears `tx_empty` on the next cycle and leaves `dre` unchanged. If both are pulsed together, the break is sent. A write accepted in the same cycle as a command waits in the holding register and follows the command frame.
- R8: `cmd_idle` and `cmd_break` are ignored while `tx_empty` = 0. The current frame and the flags are unchanged, and nothing is sent after that frame.
- R9: A `clr` pulse or an asserted `stop_mode` abandons any frame and empties the holding register. On the next cycle `dre` = 1, `tx_empty` = 1 and `txd` = 1. While `stop_mode` is high, writes and commands have no effect.
- R10: `irq` = 1 exactly when (`dre` and `ie_dre`) or (`tx_empty` and `ie_empty`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| clr | input | 1 | Synchronous transmitter clear pulse |
| stop_mode | input | 1 | Level: hold the transmitter cleared |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Holding register can take a word |
| wr_data | input | DATA_W | Word to transmit |
| cmd_idle | input | 1 | Pulse: send an idle preamble |
| cmd_break | input | 1 | Pulse: send a break |
| ie_dre | input | 1 | Interrupt enable for the holding-empty flag |
| ie_empty | input | 1 | Interrupt enable for the all-empty flag |
| txd | output | 1 | Serial line |
| dre | output | 1 | Holding-empty flag |
| tx_empty | output | 1 | All-empty flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit index or tick count inside the shifter shows up as a wrong line level at the middle of some bit, or as the holding-empty flag rising on the wrong tick. The flag check pins this to a single tick within the first 18 ticks after a load. A holding register that loses or keeps a word shows up one frame later, as a missing or extra start bit where the next frame should begin. A flag that falls out of step with the storage shows on the cycle right after the write, command or clear that should have moved it. Each of these cases is driven directly, and each result is sampled on the exact tick where the change must appear.

// File: rtl/txu_pkg.sv
package txu_pkg;

  // What the shifter is currently sending
  typedef enum logic [1:0] {
    FK_DATA  = 2'd0,
    FK_MARK  = 2'd1,
    FK_SPACE = 2'd2
  } frame_kind_e;

  function automatic int frame_len(input int dw, input int par_en);
    return dw + 2 + ((par_en != 0) ? 1 : 0);
  endfunction

endpackage

// File: rtl/txu_shifter.sv
module txu_shifter
  import txu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int PAR_EN     = 1,
  parameter int PAR_ODD    = 0,
  parameter int DRE_LAG    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tick,
  input  logic              ld_en,
  input  frame_kind_e       ld_kind,
  input  logic [DATA_W-1:0] ld_data,
  output logic              busy,
  output logic              txd,
  output logic              mark,
  output logic              frame_end
);

  localparam int NB = frame_len(DATA_W, PAR_EN);
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MARK_CNT = CW'(DRE_LAG - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NB - 1);
  localparam logic [IW-1:0] IDX_D0   = IW'(1);

  logic [NB-1:0] data_frame, ld_frame, shreg;
  logic          busy_q;
  frame_kind_e   kind_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          bit_done;

  generate
    if (PAR_EN != 0) begin : g_par
      logic pbit;
      assign pbit       = (^ld_data) ^ (PAR_ODD != 0);
      assign data_frame = {1'b1, pbit, ld_data, 1'b0};
    end else begin : g_nopar
      assign data_frame = {1'b1, ld_data, 1'b0};
    end
  endgenerate

  always_comb begin
    case (ld_kind)
      FK_MARK:  ld_frame = '1;
      FK_SPACE: ld_frame = '0;
      default:  ld_frame = data_frame;
    endcase
  end

  assign bit_done  = tick & busy_q & (cnt_q == CNT_LAST);
  assign frame_end = bit_done & (idx_q == IDX_LAST);
  assign mark      = tick & busy_q & (kind_q == FK_DATA) &
                     (idx_q == IDX_D0) & (cnt_q == MARK_CNT);
  assign txd       = busy_q ? shreg[0] : 1'b1;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= FK_MARK;
      cnt_q  <= '0;
      idx_q  <= '0;
      shreg  <= '1;
    end else if (flush) begin
      busy_q <= 1'b0;
      kind_q <= FK_MARK;
      cnt_q  <= '0;
      idx_q  <= '0;
      shreg  <= '1;
    end else if (ld_en) begin
      busy_q <= 1'b1;
      kind_q <= ld_kind;
      cnt_q  <= '0;
      idx_q  <= '0;
      shreg  <= ld_frame;
    end else if (tick && busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        shreg <= {1'b1, shreg[NB-1:1]};
        if (idx_q == IDX_LAST) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/txu_txbuf.sv
module txu_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              accept,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              take,
  input  logic              mark,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              dre
);

  logic              full_q, dre_q;
  logic [DATA_W-1:0] data_q;

  // Holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush) begin
      full_q <= 1'b0;
    end else if (put) begin
      full_q <= 1'b1;
      data_q <= put_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // Holding-empty flag: cleared by a write, set only at the in-frame mark
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dre_q <= 1'b1;
    end else if (flush) begin
      dre_q <= 1'b1;
    end else if (accept) begin
      dre_q <= 1'b0;
    end else if (mark) begin
      dre_q <= 1'b1;
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign dre  = dre_q;

endmodule

// File: rtl/txu_async_tx.sv
module txu_async_tx
  import txu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int PAR_EN     = 1,
  parameter int PAR_ODD    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              clr,
  input  logic              stop_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_idle,
  input  logic              cmd_break,
  input  logic              ie_dre,
  input  logic              ie_empty,
  output logic              txd,
  output logic              dre,
  output logic              tx_empty,
  output logic              irq
);

  logic              flush, busy, frame_end, mark;
  logic              hold_full, dre_q;
  logic [DATA_W-1:0] hold_data;
  logic              wr_fire, cmd_go, free_slot, direct, refill, ld_en;
  frame_kind_e       ld_kind;
  logic [DATA_W-1:0] ld_data;

  assign flush     = clr | stop_mode;
  assign tx_empty  = ~busy & ~hold_full;
  assign wr_ready  = dre_q & ~flush;
  assign wr_fire   = wr_valid & wr_ready;
  assign cmd_go    = tx_empty & ~flush & (cmd_idle | cmd_break);
  // shifter can take a word this cycle: idle, or its last bit ends with nothing held
  assign free_slot = ~busy | (frame_end & ~hold_full);
  assign direct    = wr_fire & ~cmd_go & free_slot;
  assign refill    = frame_end & hold_full;
  assign ld_en     = cmd_go | direct | refill;
  assign ld_kind   = cmd_go ? (cmd_break ? FK_SPACE : FK_MARK) : FK_DATA;
  assign ld_data   = direct ? wr_data : hold_data;

  txu_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .accept   (wr_fire),
    .put      (wr_fire & ~direct),
    .put_data (wr_data),
    .take     (refill),
    .mark     (mark),
    .full     (hold_full),
    .data     (hold_data),
    .dre      (dre_q)
  );

  txu_shifter #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE),
    .PAR_EN     (PAR_EN),
    .PAR_ODD    (PAR_ODD),
    .DRE_LAG    (2)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .tick      (tick16),
    .ld_en     (ld_en),
    .ld_kind   (ld_kind),
    .ld_data   (ld_data),
    .busy      (busy),
    .txd       (txd),
    .mark      (mark),
    .frame_end (frame_end)
  );

  assign dre = dre_q;
  assign irq = (dre_q & ie_dre) | (tx_empty & ie_empty);

endmodule

// File: rtl/txu_async_tx_chk.sv
module txu_async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic stop_mode,
  input logic wr_valid,
  input logic wr_ready,
  input logic cmd_break,
  input logic txd,
  input logic dre,
  input logic tx_empty
);

  a_r2_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !dre |-> !wr_ready);

  a_r2_dre_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !dre);

  a_r5_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_empty);

  a_r5_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  a_r7_break_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && cmd_break && !clr && !stop_mode) |=> (!txd && !tx_empty));

  a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || stop_mode) |=> (dre && tx_empty && txd));

endmodule

bind txu_async_tx txu_async_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .stop_mode (stop_mode),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .cmd_break (cmd_break),
  .txd       (txd),
  .dre       (dre),
  .tx_empty  (tx_empty)
);

// File: tb/tb_txu_async_tx.sv
module tb_txu_async_tx;

  localparam int NB = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       clr = 1'b0, stop_mode = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       cmd_idle = 1'b0, cmd_break = 1'b0;
  logic       ie_dre = 1'b0, ie_empty = 1'b0;
  logic       txd, dre, tx_empty, irq;

  int n_vec = 0;
  int n_bad = 0;
  int tdiv = 0;
  longint tick_total = 0;
  longint base = 0;

  always #10 clk = ~clk;

  txu_async_tx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .clr(clr), .stop_mode(stop_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cmd_idle(cmd_idle), .cmd_break(cmd_break), .ie_dre(ie_dre), .ie_empty(ie_empty),
    .txd(txd), .dre(dre), .tx_empty(tx_empty), .irq(irq)
  );

  // one tick every 4 clocks
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv = 0;
      tick16 <= 1'b0;
    end else begin
      tdiv = (tdiv + 1) % 4;
      tick16 <= (tdiv == 0);
    end
  end

  always @(posedge clk) if (rst_n && tick16) tick_total <= tick_total + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_base();
    base = tick_total;
  endtask

  task automatic to_t(input int t);
    while (tick_total - base < longint'(t)) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic idl, input logic brk);
    cmd_idle  = idl;
    cmd_break = brk;
    @(negedge clk);
    cmd_idle  = 1'b0;
    cmd_break = 1'b0;
  endtask

  // kind 0 data, 1 marks, 2 spaces
  function automatic logic fbit(input int kind, input logic [7:0] d, input int i);
    if (kind == 1) return 1'b1;
    if (kind == 2) return 1'b0;
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9) return ^d;
    return 1'b1;
  endfunction

  task automatic check_bits(input int kind, input logic [7:0] d, input int off, input int from);
    for (int i = from; i < NB; i++) begin
      to_t(off + 16*i + 8);
      chk((kind == 0) ? "R3" : "R7", $sformatf("bit%0d", i), txd, fbit(kind, d, i));
    end
  endtask

  task automatic t_reset();
    chk("R1", "dre", dre, 1);
    chk("R1", "tx_empty", tx_empty, 1);
    chk("R1", "wr_ready", wr_ready, 1);
    chk("R1", "txd", txd, 1);
    chk("R10", "irq off", irq, 0);
  endtask

  task automatic t_single(input logic [7:0] d);
    do_write(d);
    set_base();
    chk("R2", "dre after write", dre, 0);
    chk("R2", "wr_ready after write", wr_ready, 0);
    chk("R5", "tx_empty after write", tx_empty, 0);
    chk("R5", "start immediate", txd, 0);
    to_t(16);
    chk("R4", "dre at start end", dre, 0);
    to_t(17);
    chk("R4", "dre at tick17", dre, 0);
    to_t(18);
    chk("R4", "dre at tick18", dre, 1);
    check_bits(0, d, 0, 1);
    to_t(16*NB);
    chk("R5", "tx_empty at end", tx_empty, 1);
    chk("R5", "line idle at end", txd, 1);
  endtask

  task automatic t_b2b(input logic [7:0] d1, input logic [7:0] d2);
    do_write(d1);
    set_base();
    to_t(10);
    chk("R2", "no ready before mark", wr_ready, 0);
    to_t(18);
    do_write(d2);
    chk("R2", "dre after 2nd write", dre, 0);
    chk("R5", "tx_empty while held", tx_empty, 0);
    check_bits(0, d1, 0, 1);
    to_t(16*NB + 8);
    chk("R6", "next start no gap", txd, 0);
    chk("R5", "tx_empty during 2nd", tx_empty, 0);
    to_t(16*NB + 17);
    chk("R4", "dre 2nd tick17", dre, 0);
    to_t(16*NB + 18);
    chk("R4", "dre 2nd tick18", dre, 1);
    check_bits(0, d2, 16*NB, 1);
    to_t(32*NB);
    chk("R5", "tx_empty after pair", tx_empty, 1);
  endtask

  task automatic t_cmd(input logic idl, input logic brk, input int kind);
    do_cmd(idl, brk);
    set_base();
    chk("R7", "tx_empty after cmd", tx_empty, 0);
    chk("R7", "dre kept", dre, 1);
    check_bits(kind, 8'h00, 0, 0);
    to_t(16*NB);
    chk("R7", "tx_empty after cmd frame", tx_empty, 1);
    chk("R7", "line high after cmd", txd, 1);
  endtask

  task automatic t_ignore();
    do_write(8'h96);
    set_base();
    to_t(40);
    do_cmd(1'b0, 1'b1);
    chk("R8", "tx_empty kept 0", tx_empty, 0);
    chk("R8", "dre kept 1", dre, 1);
    do_cmd(1'b1, 1'b0);
    check_bits(0, 8'h96, 0, 3);
    to_t(16*NB + 8);
    chk("R8", "nothing queued", txd, 1);
    chk("R8", "empty after frame", tx_empty, 1);
  endtask

  task automatic t_cmd_write();
    cmd_idle = 1'b1;
    wr_valid = 1'b1;
    wr_data  = 8'h5A;
    @(negedge clk);
    cmd_idle = 1'b0;
    wr_valid = 1'b0;
    set_base();
    chk("R7", "dre cleared by write", dre, 0);
    chk("R7", "preamble first", txd, 1);
    to_t(88);
    chk("R7", "preamble mid", txd, 1);
    to_t(16*NB + 8);
    chk("R6", "word after preamble", txd, 0);
    check_bits(0, 8'h5A, 16*NB, 1);
    to_t(32*NB);
    chk("R5", "empty after pair", tx_empty, 1);
  endtask

  task automatic t_clear();
    do_write(8'h0F);
    set_base();
    to_t(40);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "dre after clr", dre, 1);
    chk("R9", "tx_empty after clr", tx_empty, 1);
    chk("R9", "txd after clr", txd, 1);
    to_t(100);
    chk("R9", "line stays idle", txd, 1);
    // stop mode mid-frame
    do_write(8'h33);
    set_base();
    to_t(40);
    stop_mode = 1'b1;
    @(negedge clk);
    chk("R9", "stop dre", dre, 1);
    chk("R9", "stop tx_empty", tx_empty, 1);
    chk("R9", "stop txd", txd, 1);
    chk("R2", "stop blocks ready", wr_ready, 0);
    wr_valid = 1'b1;
    wr_data  = 8'h00;
    cmd_break = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    cmd_break = 1'b0;
    @(negedge clk);
    chk("R9", "write ignored in stop", tx_empty, 1);
    chk("R9", "break ignored in stop", txd, 1);
    stop_mode = 1'b0;
    @(negedge clk);
    chk("R9", "after stop txd", txd, 1);
  endtask

  task automatic t_irq();
    ie_dre = 1'b1;
    @(negedge clk);
    chk("R10", "irq dre idle", irq, 1);
    do_write(8'hC3);
    set_base();
    chk("R10", "irq dre low", irq, 0);
    to_t(18);
    chk("R10", "irq dre at mark", irq, 1);
    ie_dre = 1'b0;
    ie_empty = 1'b1;
    @(negedge clk);
    chk("R10", "irq empty busy", irq, 0);
    to_t(16*NB);
    chk("R10", "irq empty end", irq, 1);
    ie_empty = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single(8'hA5);
    t_single(8'h00);
    t_single(8'h01);
    t_b2b(8'h3C, 8'hC3);
    t_cmd(1'b1, 1'b0, 1);
    t_cmd(1'b1, 1'b1, 2);
    t_ignore();
    t_cmd_write();
    t_clear();
    t_irq();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule